// File: doc/BRIEF.md
# Sprite Table Copy Sequencer

This block moves a fixed run of 160 bytes from a page of system memory into the sprite attribute table. A write of one byte to the control register names the source page and starts a copy. The low byte of the source address starts at zero. After a startup wait, the sequencer produces one source/destination address pair every four clocks. It then returns to idle.

The block drives no data. For each transfer it raises `xfer_valid` for one clock and presents `src_addr` and `dst_addr`. The memory datapath moves the byte on that strobe. `busy` is high only in the copy phase, so a bus arbiter can hold the processor off memory. `rdata` returns the page that was written while a copy is waiting or running. It returns 0xFF when the block is idle.

A write that arrives while a copy is waiting or running abandons that copy and starts a fresh one from the new page.

Top module: `sprite_dma`

## Requirements
- R1: While reset is applied and after it releases, `busy` and `xfer_valid` are 0 and `rdata` reads 0xFF.
- R2: A clock edge that samples `reg_wr`=1 with byte B starts a wait phase. After that edge (clock 0), `rdata` reads B and `busy` stays 0 for clocks 0 to 3.
- R3: No strobe appears during clocks 0 to 6 after a starting write.
- R4: Strobes appear on clocks 7, 11, ..., 643, which is exactly 160 strobes four clocks apart. Strobe k (k = 0..159) carries `src_addr` = {B, k}, so the offset runs from 0x00 to 0x9F in order.
- R5: On every strobe, `dst_addr` is 0xFE in bits 15:8 and the low byte of `src_addr` in bits 7:0.
- R6: `busy` is 1 on clocks 4 to 643 inclusive and 0 otherwise, and it is 1 on every strobe.
- R7: From clock 644 on, with no new write, the block is idle: `busy` is 0, there are no strobes, and `rdata` reads 0xFF.
- R8: `rdata` reads B on clocks 0 to 643.
- R9: A write during the wait phase or the copy phase restarts the sequence from the new page, with clock 0 after that write. The full set of 160 strobes follows.
- R10: Asserting `rst_n` low in the middle of a copy aborts it at once: `busy` drops to 0 and `rdata` reads 0xFF. No strobe follows after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| reg_wr | input | 1 | Control register write strobe |
| wdata | input | 8 | Source page byte written to the control register |
| rdata | output | 8 | Control register read-back |
| xfer_valid | output | 1 | One-clock strobe for a single byte transfer |
| src_addr | output | 16 | Source address; meaningful only while `xfer_valid` is 1 |
| dst_addr | output | 16 | Destination address; meaningful only while `xfer_valid` is 1 |
| busy | output | 1 | High during the copy phase |

## Verification
The bench builds the block with its default parameters: a four-clock start wait, a four-clock slot, 160 transfers and a destination page of 0xFE. With these values a single copy reaches the top offset 0x9F and the 644-clock end point. The bench uses pages 0x00, 0x80, 0xC0 and 0xFF, so read-back of 0xFF on a live copy can be told apart from read-back of an idle block. It also checks a restart from the wait phase, a restart from the middle of a copy, and an asynchronous reset in the middle of a copy.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_COPY = 2'd2
  } sdma_state_e;
endpackage

// File: rtl/sdma_rst_sync.sv
module sdma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int START_DLY = 4,
  parameter int SLOT      = 4,
  parameter int NUM_XFER  = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output sdma_state_e state_o,
  output logic        strobe_o
);
  localparam int TOTAL = START_DLY + SLOT * NUM_XFER;
  localparam int CW    = $clog2(TOTAL + 1);

  sdma_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] rel;
  logic          slot_end, last_clk, cnt_en;

  // Position inside the copy phase and end-of-slot detection
  always_comb begin
    rel      = cnt_q - CW'(START_DLY);
    slot_end = (rel % CW'(SLOT)) == CW'(SLOT - 1);
    last_clk = cnt_q == CW'(TOTAL - 1);
    strobe_o = (state_q == ST_COPY) && slot_end && !start_i;
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start_i) begin
      state_d = ST_WAIT;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        ST_WAIT: begin
          cnt_d  = cnt_q + CW'(1);
          cnt_en = 1'b1;
          if (cnt_q == CW'(START_DLY - 1)) state_d = ST_COPY;
        end
        ST_COPY: begin
          cnt_en = 1'b1;
          if (last_clk) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
  parameter int          PAGE_W   = 8,
  parameter int          OFF_W    = 8,
  parameter logic [7:0]  DST_PAGE = 8'hFE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [PAGE_W-1:0]       page_i,
  input  logic                    advance_i,
  output logic [PAGE_W-1:0]       page_o,
  output logic [PAGE_W+OFF_W-1:0] src_o,
  output logic [PAGE_W+OFF_W-1:0] dst_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              off_en;

  always_comb begin
    off_en = load_i || advance_i;
    off_d  = load_i ? '0 : off_q + OFF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      page_q <= '0;
    else if (load_i) page_q <= page_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign page_o = page_q;
  assign src_o  = {page_q, off_q};
  assign dst_o  = {PAGE_W'(DST_PAGE), off_q};
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sdma_pkg::*;
#(
  parameter int         START_DLY = 4,
  parameter int         SLOT      = 4,
  parameter int         NUM_XFER  = 160,
  parameter logic [7:0] DST_PAGE  = 8'hFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        xfer_valid,
  output logic [15:0] src_addr,
  output logic [15:0] dst_addr,
  output logic        busy
);
  localparam int PAGE_W = 8;
  localparam int OFF_W  = 8;

  logic        rst_int_n;
  sdma_state_e state;
  logic        strobe;
  logic [7:0]  page;

  sdma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  sdma_seq #(
    .START_DLY (START_DLY),
    .SLOT      (SLOT),
    .NUM_XFER  (NUM_XFER)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (reg_wr),
    .state_o  (state),
    .strobe_o (strobe)
  );

  sdma_addr #(
    .PAGE_W   (PAGE_W),
    .OFF_W    (OFF_W),
    .DST_PAGE (DST_PAGE)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (reg_wr),
    .page_i    (wdata),
    .advance_i (strobe),
    .page_o    (page),
    .src_o     (src_addr),
    .dst_o     (dst_addr)
  );

  assign xfer_valid = strobe;
  assign busy       = (state == ST_COPY);
  assign rdata      = (state == ST_IDLE) ? 8'hFF : page;
endmodule

// File: rtl/sprite_dma_checker.sv
module sprite_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        xfer_valid,
  input logic [15:0] src_addr,
  input logic [15:0] dst_addr,
  input logic        busy
);
  a_r2_write_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (!busy && rdata == $past(wdata)));

  a_r3_quiet_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !xfer_valid);

  a_r4_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !reg_wr) |=> !xfer_valid ##1 !xfer_valid ##1 !xfer_valid);

  a_r5_dst_page: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (dst_addr[15:8] == 8'hFE && dst_addr[7:0] == src_addr[7:0]));

  a_r6_strobe_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> busy);

  a_r7_idle_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(reg_wr)) |-> rdata == 8'hFF);
endmodule

bind sprite_dma sprite_dma_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .wdata      (wdata),
  .rdata      (rdata),
  .xfer_valid (xfer_valid),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .busy       (busy)
);

// File: tb/sprite_dma_bench.sv
module sprite_dma_bench;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        xfer_valid;
  logic [15:0] src_addr;
  logic [15:0] dst_addr;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  // {page, expected first source, expected last destination}
  localparam logic [39:0] VECS [4] = '{
    {8'h80, 16'h8000, 16'hFE9F},
    {8'hC0, 16'hC000, 16'hFE9F},
    {8'h00, 16'h0000, 16'hFE9F},
    {8'hFF, 16'hFF00, 16'hFE9F}
  };

  sprite_dma u_sprite_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .wdata      (wdata),
    .rdata      (rdata),
    .xfer_valid (xfer_valid),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .busy       (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk);
    reg_wr = 1'b1;
    wdata  = b;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Called at the observation point of clock 0; checks clocks 0..nmax
  task automatic track(input logic [7:0] page, input int nmax,
                       output logic [15:0] first_src, output logic [15:0] last_dst,
                       output int nstrb);
    nstrb     = 0;
    first_src = 16'hxxxx;
    last_dst  = 16'hxxxx;
    for (int n = 0; n <= nmax; n++) begin
      bit         busy_e, val_e;
      logic [7:0] rd_e;
      busy_e = (n >= 4) && (n < 644);
      val_e  = (n >= 7) && (n <= 643) && (((n - 7) % 4) == 0);
      rd_e   = (n < 644) ? page : 8'hFF;
      chk(busy === busy_e, (n < 4) ? "R2" : "R6", 32'(busy), 32'(busy_e));
      chk(xfer_valid === val_e, (n < 7) ? "R3" : ((n >= 644) ? "R7" : "R4"),
          32'(xfer_valid), 32'(val_e));
      chk(rdata === rd_e, (n >= 644) ? "R7" : "R8", 32'(rdata), 32'(rd_e));
      if (val_e) begin
        logic [15:0] s_e;
        s_e = {page, 8'((n - 7) / 4)};
        chk(src_addr === s_e, "R4", 32'(src_addr), 32'(s_e));
        chk(dst_addr === {8'hFE, s_e[7:0]}, "R5", 32'(dst_addr), 32'({8'hFE, s_e[7:0]}));
        if (nstrb == 0) first_src = src_addr;
        last_dst = dst_addr;
        nstrb++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] fs, ld;
    int          ns;
    rst_n  = 1'b0;
    reg_wr = 1'b0;
    wdata  = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1", 32'(busy), 0);
    chk(xfer_valid === 1'b0, "R1", 32'(xfer_valid), 0);
    chk(rdata === 8'hFF, "R1", 32'(rdata), 32'hFF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdata === 8'hFF && busy === 1'b0, "R1", 32'({busy, rdata}), 32'h0FF);

    // Vector table: full copies from several pages
    for (int i = 0; i < 4; i++) begin
      do_write(VECS[i][39:32]);
      track(VECS[i][39:32], 650, fs, ld, ns);
      chk(ns == 160, "R4", 32'(ns), 160);
      chk(fs === VECS[i][31:16], "R4", 32'(fs), 32'(VECS[i][31:16]));
      chk(ld === VECS[i][15:0], "R5", 32'(ld), 32'(VECS[i][15:0]));
    end

    // R9: restart in the middle of a copy
    do_write(8'h40);
    track(8'h40, 100, fs, ld, ns);
    do_write(8'h55);
    track(8'h55, 650, fs, ld, ns);
    chk(ns == 160, "R9", 32'(ns), 160);
    chk(fs === 16'h5500, "R9", 32'(fs), 32'h5500);

    // R9: restart during the wait phase
    do_write(8'h11);
    track(8'h11, 1, fs, ld, ns);
    do_write(8'h22);
    track(8'h22, 650, fs, ld, ns);
    chk(ns == 160, "R9", 32'(ns), 160);
    chk(fs === 16'h2200, "R9", 32'(fs), 32'h2200);

    // R10: asynchronous reset in the middle of a copy
    do_write(8'h33);
    track(8'h33, 20, fs, ld, ns);
    rst_n = 1'b0;
    #2;
    chk(busy === 1'b0, "R10", 32'(busy), 0);
    chk(rdata === 8'hFF, "R10", 32'(rdata), 32'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    ns = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (xfer_valid !== 1'b0 || busy !== 1'b0) ns++;
    end
    chk(ns == 0, "R10", 32'(ns), 0);
    chk(rdata === 8'hFF, "R10", 32'(rdata), 32'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule